// File: doc/BRIEF.md
# Link Interface Power-State Controller

This block sits between a PHY core and a link-layer controller and decides, from the link's power-status input, how much of the PHY-to-link interface stays alive. The block counts how long that input has been low, using a free-running local clock. A short low period is ignored. A low period longer than a first limit puts the interface into a low-power reset state. In that state the control and data lines to the link are forced to zero and link requests are dropped, but the link clock keeps running. A low period longer than a second, larger limit also stops the link clock. This is the disabled state.

As soon as the power-status input is seen high again, the interface goes back to normal. If it comes back from the disabled state, the block raises a one-cycle bus-reset request. The bus-reset logic uses that request to advertise that the link can be reached again. Hardware reset holds the interface in the disabled state. The link clock is half the local clock rate. It is gated by an enable that changes only while the gated clock is low.

Top module: `linkPowerCtl`

## Requirements
- R1: While `rstN` is low, `ifState` is 2'b10, `linkActive` is 0, and `linkClkOut`, `linkCtlOut`, `linkDataOut` and `linkReqOut` are all 0.
- R2: A low period on `linkPwrIn` that spans at most RST_LIMIT consecutive rising edges leaves `ifState` at 2'b00 (normal).
- R3: With the default two synchronizer stages, a low period spanning at least RST_LIMIT+1 edges sets `ifState` to 2'b01 (reset) on edge RST_LIMIT+3 of the period. Edge 1 is the first edge that samples the low level. A rising edge of the input restarts the count.
- R4: In state 2'b01, `linkCtlOut` and `linkDataOut` are 0 and `linkReqOut` is 0 whatever `linkReqIn` is. `linkClkOut` keeps toggling, high on every second edge.
- R5: A low period spanning at least DIS_LIMIT+1 edges sets `ifState` to 2'b10 (disabled) on edge DIS_LIMIT+3 of the period.
- R6: In state 2'b10, `linkClkOut` is held at 0 from at most two edges after entry.
- R7: From state 2'b01 or 2'b10, `ifState` returns to 2'b00 on the second edge after the first edge that samples the input high.
- R8: `busResetReq` is high for exactly one cycle, on the same edge as a return to 2'b00 from 2'b10. It is never high on a return from 2'b01. This includes the first wake-up after hardware reset.
- R9: In state 2'b00, `linkActive` is 1 and `linkCtlOut`, `linkDataOut` and `linkReqOut` follow `phyCtlIn`, `phyDataIn` and `linkReqIn`.
- R10: Every high pulse of `linkClkOut` lasts exactly one local clock cycle, including pulses at enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| linkPwrIn | input | 1 | Power-status level from the link controller (asynchronous) |
| phyCtlIn | input | CTL_W | Control value the PHY wants to present to the link |
| phyDataIn | input | DATA_W | Data value the PHY wants to present to the link |
| linkReqIn | input | 1 | Request line from the link |
| linkCtlOut | output | CTL_W | Gated control lines to the link |
| linkDataOut | output | DATA_W | Gated data lines to the link |
| linkReqOut | output | 1 | Gated request towards the PHY core |
| linkClkOut | output | 1 | Gated link clock, half the local rate |
| busResetReq | output | 1 | One-cycle bus-reset request on wake from disabled |
| ifState | output | 2 | 00 normal, 01 low-power reset, 10 disabled |
| linkActive | output | 1 | High in the normal state |

## Verification
`ifState` and `busResetReq` change on the second edge after the input change is sampled, after the two synchronizer flops. The threshold crossings land on edge RST_LIMIT+3 and edge DIS_LIMIT+3 of a low period. The gated data, control and request outputs follow the state register in the same cycle and follow the PHY-side inputs combinationally. The clock output follows a toggle flop and an enable flop that loads only on edges where the toggle was low. The bench runs a cycle-exact model of this pipeline, updated on each rising edge from the levels it drove half a cycle before. It compares every output on the falling edge, after all registers have settled and before the next stimulus. Directed low periods of exactly RST_LIMIT, RST_LIMIT+1, DIS_LIMIT and DIS_LIMIT+1 edges pin down the boundaries of both thresholds.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL   = 2'b00,
    ST_RESET    = 2'b01,
    ST_DISABLED = 2'b10
  } lpcState_e;

  // strobes from the control half to the gating datapath
  typedef struct packed {
    logic passLink;   // interface fully open
    logic clkRun;     // link clock may run
  } lpcStrobe_t;

endpackage

// File: rtl/lpcCtrl.sv
module lpcCtrl
  import lpc_pkg::*;
#(
  parameter int RST_LIMIT   = 20,
  parameter int DIS_LIMIT   = 60,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       linkPwrIn,
  output lpcState_e  state,
  output lpcStrobe_t strobe,
  output logic       busResetReq
);

  localparam int CNT_W = $clog2(DIS_LIMIT + 1);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(RST_LIMIT);
  localparam logic [CNT_W-1:0] DIS_CNT = CNT_W'(DIS_LIMIT);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pwrSeen;
  logic [CNT_W-1:0]       lowCnt;
  lpcState_e              nextState;

  // input synchronizer, depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= linkPwrIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], linkPwrIn};
      end
    end
  endgenerate

  assign pwrSeen = syncQ[SYNC_STAGES-1];

  // low-duration counter, cleared by any high sample, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (pwrSeen)         lowCnt <= '0;
    else if (lowCnt != DIS_CNT) lowCnt <= lowCnt + 1'b1;
  end

  always_comb begin
    nextState = state;
    if (pwrSeen)                nextState = ST_NORMAL;
    else if (lowCnt >= DIS_CNT) nextState = ST_DISABLED;
    else if (lowCnt >= RST_CNT && state != ST_DISABLED) nextState = ST_RESET;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_DISABLED;
      busResetReq <= 1'b0;
    end else begin
      state       <= nextState;
      busResetReq <= pwrSeen && (state == ST_DISABLED);
    end
  end

  assign strobe.passLink = (state == ST_NORMAL);
  assign strobe.clkRun   = (state != ST_DISABLED);

endmodule

// File: rtl/lpcGate.sv
module lpcGate
  import lpc_pkg::*;
#(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpcStrobe_t        strobe,
  input  logic [CTL_W-1:0]  phyCtlIn,
  input  logic [DATA_W-1:0] phyDataIn,
  input  logic              linkReqIn,
  output logic [CTL_W-1:0]  linkCtlOut,
  output logic [DATA_W-1:0] linkDataOut,
  output logic              linkReqOut,
  output logic              linkClkOut
);

  logic clkTog;
  logic clkEn;

  assign linkCtlOut  = strobe.passLink ? phyCtlIn  : '0;
  assign linkDataOut = strobe.passLink ? phyDataIn : '0;
  assign linkReqOut  = strobe.passLink & linkReqIn;

  // half-rate clock; enable loads only while the gated clock is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkTog <= 1'b0;
      clkEn  <= 1'b0;
    end else begin
      clkTog <= ~clkTog;
      if (!clkTog) clkEn <= strobe.clkRun;
    end
  end

  assign linkClkOut = clkTog & clkEn;

endmodule

// File: rtl/linkPowerCtl.sv
module linkPowerCtl
  import lpc_pkg::*;
#(
  parameter int RST_LIMIT   = 20,
  parameter int DIS_LIMIT   = 60,
  parameter int SYNC_STAGES = 2,
  parameter int CTL_W       = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkPwrIn,
  input  logic [CTL_W-1:0]  phyCtlIn,
  input  logic [DATA_W-1:0] phyDataIn,
  input  logic              linkReqIn,
  output logic [CTL_W-1:0]  linkCtlOut,
  output logic [DATA_W-1:0] linkDataOut,
  output logic              linkReqOut,
  output logic              linkClkOut,
  output logic              busResetReq,
  output logic [1:0]        ifState,
  output logic              linkActive
);

  lpcState_e  state;
  lpcStrobe_t strobe;

  lpcCtrl #(
    .RST_LIMIT  (RST_LIMIT),
    .DIS_LIMIT  (DIS_LIMIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .linkPwrIn  (linkPwrIn),
    .state      (state),
    .strobe     (strobe),
    .busResetReq(busResetReq)
  );

  lpcGate #(
    .CTL_W (CTL_W),
    .DATA_W(DATA_W)
  ) u_gate (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phyCtlIn   (phyCtlIn),
    .phyDataIn  (phyDataIn),
    .linkReqIn  (linkReqIn),
    .linkCtlOut (linkCtlOut),
    .linkDataOut(linkDataOut),
    .linkReqOut (linkReqOut),
    .linkClkOut (linkClkOut)
  );

  assign ifState    = state;
  assign linkActive = strobe.passLink;

endmodule

// File: rtl/linkPowerCtl_chk.sv
module linkPowerCtl_chk #(
  parameter int CTL_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              linkReqIn,
  input logic [CTL_W-1:0]  linkCtlOut,
  input logic [DATA_W-1:0] linkDataOut,
  input logic              linkReqOut,
  input logic              linkClkOut,
  input logic              busResetReq,
  input logic [1:0]        ifState
);

  assert_legal_state_R3: assert property (@(posedge clk) disable iff (!rstN)
    ifState != 2'b11);

  assert_quiet_outputs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ifState != 2'b00) |-> (linkCtlOut == '0 && linkDataOut == '0 && !linkReqOut));

  assert_clock_stopped_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ifState == 2'b10 && $past(ifState) == 2'b10 && $past(ifState, 2) == 2'b10)
      |-> !linkClkOut);

  assert_bus_reset_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    busResetReq |-> (ifState == 2'b00 && $past(ifState) == 2'b10));

  assert_bus_reset_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    busResetReq |=> !busResetReq);

  assert_req_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    linkReqOut |-> (linkReqIn && ifState == 2'b00));

  assert_clock_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    linkClkOut |=> !linkClkOut);

endmodule

bind linkPowerCtl linkPowerCtl_chk #(.CTL_W(CTL_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .linkReqIn  (linkReqIn),
  .linkCtlOut (linkCtlOut),
  .linkDataOut(linkDataOut),
  .linkReqOut (linkReqOut),
  .linkClkOut (linkClkOut),
  .busResetReq(busResetReq),
  .ifState    (ifState)
);

// File: tb/test_linkPowerCtl.sv
`timescale 1ns/1ps
module test_linkPowerCtl;

  localparam int RST = 20;
  localparam int DIS = 60;
  localparam int CW  = 2;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          linkPwrIn = 1'b0;
  logic [CW-1:0] phyCtlIn = '0;
  logic [DW-1:0] phyDataIn = '0;
  logic          linkReqIn = 1'b0;
  logic [CW-1:0] linkCtlOut;
  logic [DW-1:0] linkDataOut;
  logic          linkReqOut, linkClkOut, busResetReq, linkActive;
  logic [1:0]    ifState;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  linkPowerCtl #(.RST_LIMIT(RST), .DIS_LIMIT(DIS), .SYNC_STAGES(2),
                 .CTL_W(CW), .DATA_W(DW)) i_linkPowerCtl (
    .clk(clk), .rstN(rstN), .linkPwrIn(linkPwrIn), .phyCtlIn(phyCtlIn),
    .phyDataIn(phyDataIn), .linkReqIn(linkReqIn), .linkCtlOut(linkCtlOut),
    .linkDataOut(linkDataOut), .linkReqOut(linkReqOut), .linkClkOut(linkClkOut),
    .busResetReq(busResetReq), .ifState(ifState), .linkActive(linkActive)
  );

  // cycle-exact reference model built from the requirements
  logic       mS1, mS2, mBus, mTog, mEn;
  int         mCnt;
  logic [1:0] mSt, mPrevSt;
  logic       prevClk;

  function automatic logic [1:0] nextSt(logic seen, int cnt, logic [1:0] cur);
    if (seen)       return 2'b00;
    if (cnt >= DIS) return 2'b10;
    if (cnt >= RST) return (cur == 2'b10) ? 2'b10 : 2'b01;
    return cur;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mCnt <= 0; mSt <= 2'b10; mPrevSt <= 2'b10;
      mBus <= 0; mTog <= 0; mEn <= 0;
    end else begin
      mS1     <= linkPwrIn;
      mS2     <= mS1;
      mCnt    <= mS2 ? 0 : ((mCnt < DIS) ? mCnt + 1 : mCnt);
      mPrevSt <= mSt;
      mSt     <= nextSt(mS2, mCnt, mSt);
      mBus    <= mS2 && (mSt == 2'b10);
      mTog    <= ~mTog;
      if (!mTog) mEn <= (mSt != 2'b10);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    logic act;
    string stTag, gTag, cTag;
    act   = (mSt == 2'b00);
    stTag = (!rstN) ? "R1" : (mSt == 2'b01) ? "R3" : (mSt == 2'b10) ? "R5" :
            (mPrevSt != 2'b00) ? "R7" : "R2";
    gTag  = (!rstN) ? "R1" : act ? "R9" : "R4";
    cTag  = (!rstN) ? "R1" : (mSt == 2'b10) ? "R6" : "R4";
    chk(stTag, "ifState", ifState, mSt);
    chk(gTag, "linkActive", linkActive, act);
    chk(gTag, "linkCtlOut", linkCtlOut, act ? phyCtlIn : 0);
    chk(gTag, "linkDataOut", linkDataOut, act ? phyDataIn : 0);
    chk(gTag, "linkReqOut", linkReqOut, act ? linkReqIn : 0);
    chk(cTag, "linkClkOut", linkClkOut, mTog & mEn);
    chk("R8", "busResetReq", busResetReq, mBus);
    if (prevClk) chk("R10", "linkClkOut second cycle", linkClkOut, 0);
    prevClk = linkClkOut;
  endtask

  task automatic step(logic pwr);
    @(negedge clk);
    checkAll();
    linkPwrIn = pwr;
    phyCtlIn  = CW'($urandom);
    phyDataIn = DW'($urandom);
    linkReqIn = 1'($urandom);
  endtask

  task automatic runLevel(logic pwr, int n);
    for (int i = 0; i < n; i++) step(pwr);
  endtask

  initial begin
    int unused;
    unused  = $urandom(32'h1A2B3C);
    prevClk = 0;
    runLevel(0, 5);            // R1 during reset
    @(negedge clk); rstN = 1;
    runLevel(1, 30);           // wake from disabled after reset: R8
    // directed threshold boundaries
    runLevel(0, RST);     runLevel(1, 20);   // R2 longest ignored
    runLevel(0, RST + 1); runLevel(1, 20);   // R3 shortest reset
    runLevel(0, DIS);     runLevel(1, 20);   // R5 just below
    runLevel(0, DIS + 1); runLevel(1, 20);   // R5 shortest disable, R8
    runLevel(0, 1);       runLevel(1, 1);    // glitches, R2
    runLevel(0, RST - 1); runLevel(1, 1); runLevel(0, RST - 1); runLevel(1, 20);
    // hardware reset in the middle of a reset-state period
    runLevel(0, RST + 10);
    @(negedge clk); rstN = 0;
    runLevel(0, 4);
    @(negedge clk); rstN = 1;
    runLevel(1, 20);
    // constrained random segments
    for (int s = 0; s < 80; s++) begin
      int lo;
      case ($urandom_range(0, 3))
        0: lo = $urandom_range(1, RST);
        1: lo = $urandom_range(RST + 1, DIS);
        2: lo = $urandom_range(DIS + 1, DIS + 40);
        default: lo = $urandom_range(RST - 1, RST + 2);
      endcase
      runLevel(0, lo);
      runLevel(1, $urandom_range(1, 30));
    end
    runLevel(1, 4);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule